// File: doc/BRIEF.md
# SCSI Initiator Phase Sequencer

This block runs one SCSI command from the initiator side with no processor help during the command. A one-cycle `start` gives the target ID (placed on the data bus during selection) and a table of eight buffer pointers, one per phase code. The sequencer first waits for the bus to be free. It then selects the target and follows whatever information-transfer phase the target announces. Each byte moves through an asynchronous REQ/ACK handshake between the bus and a byte-wide memory port. When the command ends, the block pulses `done`. The result code is held, and the final pointer table shows how far each phase buffer advanced.

The control is one state machine with the following states.
- `S_IDLE` waits for `start` and goes to `S_BUSRST` if a reset is pending, otherwise to `S_FREE_A`.
- `S_BUSRST` drives RST for `RST_CYC` cycles. It then goes to `S_DONE` if it was entered because of an error, or to `S_FREE_A` if it was entered at start.
- `S_FREE_A` takes the first bus-free sample and goes to `S_FREE_B` when the bus is free.
- `S_FREE_B` waits `FREE_GAP` cycles and samples again. It goes to `S_SELECT` if the bus is still free, or back to `S_FREE_A`.
- Leaving `S_FREE_A` or `S_FREE_B` after too many failed samples goes to `S_DONE`.
- `S_SELECT` goes to `S_AWAIT_REQ` when the target answers with BSY, or to `S_BUSRST` on timeout.
- `S_AWAIT_REQ` goes to `S_XFER` when it sees REQ in command phase, or to `S_BUSRST` on a wrong phase or a timeout.
- `S_XFER` goes to `S_ACK` for each byte. It goes to `S_DONE` on success and to `S_BUSRST` on any other ending.
- `S_ACK` returns to `S_XFER` once REQ falls, or goes to `S_BUSRST` when the watchdog expires.
- `S_DONE` returns to `S_IDLE`.

Every SCSI input passes through a two-flop synchronizer before the state machine sees it. All limits are parameters counted in clock cycles.

Top module: `scsi_init_seq`

## Requirements
- R1: After reset, `done`, `result`, `sel_o`, `ack_o`, `rst_o` and `db_oe` are all 0.
- R2: The bus counts as free only if BSY and SEL are both low on two samples `FREE_GAP` cycles apart. After `FREE_TRIES` failed samples the command ends with result 5 and no RST. The next command then begins with a bus reset before it selects.
- R3: During selection `sel_o` is high, `db_oe` is high and `db_o` equals the target ID. If BSY does not arrive within `SEL_LIMIT` cycles, the result is 5 and a bus reset follows.
- R4: Once BSY is seen, SEL and the data drivers are released and the block waits for REQ. If REQ does not arrive within `REQ_LIMIT` cycles, the result is 5. If the first phase is not command (code 2), the result is 4. Both cases are followed by a bus reset.
- R5: The phase is {MSG, C/D, I/O}: 0 data-out, 1 data-in, 2 command, 3 status, 7 message-in. Bit 0 set means target-to-initiator. Such bytes are written to memory at the current pointer. In the other phases, memory is read at the pointer and the byte is driven on `db_o`.
- R6: Each byte raises `ack_o` only after REQ is high and drops it after REQ falls. Each byte advances the current pointer by one.
- R7: On a phase change the current pointer is written back into the slot of the phase being left, and the pointer for the new phase is loaded. At the end, the pointer of the last phase is written back too. `final_ptrs` slot k sits at bits [8k+7:8k].
- R8: Entering a phase whose slot is zero ends the command with result 4, followed by a bus reset.
- R9: When BSY drops, the result is 1 if at least one message-in byte was transferred, with no bus reset. Otherwise the result is 2, followed by a bus reset.
- R10: Sensing RST on the bus while connected ends the command with result 3, followed by a bus reset.
- R11: If the transfer phase lasts `XFER_LIMIT` cycles, the command ends with result 5, followed by a bus reset.
- R12: `done` is a one-cycle pulse with a nonzero `result`. Every bus reset holds `rst_o` for exactly `RST_CYC` cycles with the data drivers off. An error's reset finishes before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (one cycle, accepted in idle) |
| start_id | input | 8 | Selection pattern placed on the data bus |
| start_ptrs | input | 64 | Initial pointer per phase code, slot k at [8k+7:8k] |
| mem_addr | output | 8 | Buffer memory address |
| mem_wr | output | 1 | Buffer memory write strobe |
| mem_wdata | output | 8 | Buffer memory write data |
| mem_rdata | input | 8 | Buffer memory read data (combinational from mem_addr) |
| db_i | input | 8 | SCSI data bus sensed |
| db_o | output | 8 | SCSI data bus driven value |
| db_oe | output | 1 | SCSI data bus drive enable |
| bsy_i | input | 1 | BSY sensed |
| sel_i | input | 1 | SEL sensed |
| req_i | input | 1 | REQ from the target |
| cd_i | input | 1 | C/D from the target |
| io_i | input | 1 | I/O from the target |
| msg_i | input | 1 | MSG from the target |
| rst_i | input | 1 | RST sensed on the bus |
| sel_o | output | 1 | SEL driven by the initiator |
| ack_o | output | 1 | ACK driven by the initiator |
| rst_o | output | 1 | RST driven by the initiator |
| done | output | 1 | Command finished (one-cycle pulse) |
| result | output | 3 | Result code, held until the next start |
| final_ptrs | output | 64 | Pointer table after the command |

## Verification
The assertions assume that the target settles the phase lines and DATA before it raises REQ, and holds them until it sees ACK. This keeps the synchronized copies consistent with one another. The bench target model changes the phase lines and data on one falling edge and raises REQ on a later one. It lowers REQ only after it sees ACK, and drops BSY only between bytes. A reference monitor samples every clock a quarter period after the rising edge. It tracks selection data, the ACK-after-REQ order and the length of each reset pulse, and compares them with the requirements.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;
    localparam logic [2:0] PH_CMD   = 3'd2;
    localparam logic [2:0] PH_MSGIN = 3'd7;

    typedef enum logic [2:0] {
        RC_PENDING = 3'd0,
        RC_OK      = 3'd1,
        RC_DROP    = 3'd2,
        RC_BUSRST  = 3'd3,
        RC_NOPTR   = 3'd4,
        RC_TIMEOUT = 3'd5
    } rcode_t;

    typedef enum logic [3:0] {
        S_IDLE, S_BUSRST, S_FREE_A, S_FREE_B, S_SELECT,
        S_AWAIT_REQ, S_XFER, S_ACK, S_DONE
    } seq_t;
endpackage

// File: rtl/scsi_sync.sv
module scsi_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/scsi_ptr_table.sv
module scsi_ptr_table #(
    parameter int AW    = 8,
    parameter int NSLOT = 8,
    localparam int IW   = $clog2(NSLOT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [AW*NSLOT-1:0] load_val,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [AW-1:0]       wr_val,
    input  logic [IW-1:0]       rd_idx,
    output logic [AW-1:0]       rd_val,
    output logic [AW*NSLOT-1:0] all
);
    logic [AW-1:0] slot [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot[k] <= '0;
            else if (load)
                slot[k] <= load_val[k*AW +: AW];
            else if (wr_en && wr_idx == IW'(k))
                slot[k] <= wr_val;
        end
        assign all[k*AW +: AW] = slot[k];
    end

    assign rd_val = slot[rd_idx];

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> all == $past(load_val));
endmodule

// File: rtl/scsi_init_seq.sv
module scsi_init_seq
    import scsi_seq_pkg::*;
#(
    parameter int AW         = 8,
    parameter int FREE_TRIES = 4,
    parameter int FREE_GAP   = 4,
    parameter int RST_CYC    = 6,
    parameter int SEL_LIMIT  = 24,
    parameter int REQ_LIMIT  = 24,
    parameter int XFER_LIMIT = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        start_id,
    input  logic [8*AW-1:0]   start_ptrs,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        db_i,
    output logic [7:0]        db_o,
    output logic              db_oe,
    input  logic              bsy_i,
    input  logic              sel_i,
    input  logic              req_i,
    input  logic              cd_i,
    input  logic              io_i,
    input  logic              msg_i,
    input  logic              rst_i,
    output logic              sel_o,
    output logic              ack_o,
    output logic              rst_o,
    output logic              done,
    output logic [2:0]        result,
    output logic [8*AW-1:0]   final_ptrs
);
    localparam int NSLOT = 8;
    localparam int TA    = (SEL_LIMIT > REQ_LIMIT) ? SEL_LIMIT : REQ_LIMIT;
    localparam int TB    = (RST_CYC > FREE_GAP) ? RST_CYC : FREE_GAP;
    localparam int TMAX  = (TA > TB) ? TA : TB;
    localparam int TW    = $clog2(TMAX + 2);
    localparam int WW    = $clog2(XFER_LIMIT + 2);
    localparam int FTW   = $clog2(FREE_TRIES + 1);

    // synchronized bus inputs
    logic [7:0] db_s;
    logic       rst_s, bsy_s, sel_s, req_s, msg_s, cd_s, io_s;
    logic [2:0] phase_s;

    scsi_sync #(.W(15)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rst_i, bsy_i, sel_i, req_i, msg_i, cd_i, io_i, db_i}),
        .q     ({rst_s, bsy_s, sel_s, req_s, msg_s, cd_s, io_s, db_s})
    );
    assign phase_s = {msg_s, cd_s, io_s};

    seq_t          st, st_nx;
    rcode_t        res_q, fin;
    logic [TW-1:0] tmr, lim_m1;
    logic [WW-1:0] wdog;
    logic [FTW-1:0] tries;
    logic          need_rst, rst_end, msg_got;
    logic [2:0]    cur_phase;
    logic [AW-1:0] cur_ptr, new_ptr;
    logic [7:0]    db_q, id_q;
    logic          tmr_hit, wd_exp, free_now, last_try, first_ok;
    logic          byte_go, ph_sw, tab_wr;

    scsi_ptr_table #(.AW(AW), .NSLOT(NSLOT)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st == S_IDLE && start),
        .load_val (start_ptrs),
        .wr_en    (tab_wr),
        .wr_idx   (cur_phase),
        .wr_val   (cur_ptr),
        .rd_idx   (phase_s),
        .rd_val   (new_ptr),
        .all      (final_ptrs)
    );

    always_comb begin
        unique case (st)
            S_BUSRST:    lim_m1 = TW'(RST_CYC - 1);
            S_FREE_B:    lim_m1 = TW'(FREE_GAP - 1);
            S_SELECT:    lim_m1 = TW'(SEL_LIMIT - 1);
            S_AWAIT_REQ: lim_m1 = TW'(REQ_LIMIT - 1);
            default:     lim_m1 = '1;
        endcase
    end

    assign tmr_hit  = (tmr == lim_m1);
    assign wd_exp   = (wdog >= WW'(XFER_LIMIT));
    assign free_now = !bsy_s && !sel_s;
    assign last_try = (tries == FTW'(FREE_TRIES - 1));
    assign first_ok = (phase_s == PH_CMD) && (new_ptr != '0);

    // outcome of the connected phase, in priority order
    always_comb begin
        fin = RC_PENDING;
        if (st == S_XFER) begin
            if (wd_exp)                                          fin = RC_TIMEOUT;
            else if (!bsy_s)                                     fin = msg_got ? RC_OK : RC_DROP;
            else if (rst_s)                                      fin = RC_BUSRST;
            else if (req_s && phase_s != cur_phase && new_ptr == '0) fin = RC_NOPTR;
        end else if (st == S_ACK && wd_exp) begin
            fin = RC_TIMEOUT;
        end
    end

    assign byte_go = (st == S_XFER) && (fin == RC_PENDING) && req_s && (phase_s == cur_phase);
    assign ph_sw   = (st == S_XFER) && (fin == RC_PENDING) && req_s && (phase_s != cur_phase);
    assign tab_wr  = ph_sw || (fin != RC_PENDING);

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:      if (start) st_nx = need_rst ? S_BUSRST : S_FREE_A;
            S_BUSRST:    if (tmr_hit) st_nx = rst_end ? S_DONE : S_FREE_A;
            S_FREE_A:    if (free_now) st_nx = S_FREE_B;
                         else if (last_try) st_nx = S_DONE;
            S_FREE_B:    if (tmr_hit) begin
                             if (free_now)      st_nx = S_SELECT;
                             else if (last_try) st_nx = S_DONE;
                             else               st_nx = S_FREE_A;
                         end
            S_SELECT:    if (bsy_s) st_nx = S_AWAIT_REQ;
                         else if (tmr_hit) st_nx = S_BUSRST;
            S_AWAIT_REQ: if (req_s) st_nx = first_ok ? S_XFER : S_BUSRST;
                         else if (tmr_hit) st_nx = S_BUSRST;
            S_XFER:      if (fin == RC_OK) st_nx = S_DONE;
                         else if (fin != RC_PENDING) st_nx = S_BUSRST;
                         else if (byte_go) st_nx = S_ACK;
            S_ACK:       if (fin != RC_PENDING) st_nx = S_BUSRST;
                         else if (!req_s) st_nx = S_XFER;
            S_DONE:      st_nx = S_IDLE;
            default:     st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr       <= '0;
            wdog      <= '0;
            tries     <= '0;
            need_rst  <= 1'b0;
            rst_end   <= 1'b0;
            msg_got   <= 1'b0;
            res_q     <= RC_PENDING;
            cur_phase <= '0;
            cur_ptr   <= '0;
            db_q      <= '0;
            id_q      <= '0;
        end else begin
            tmr <= (st_nx != st) ? '0 : tmr + 1'b1;

            if (st == S_AWAIT_REQ)                         wdog <= '0;
            else if ((st == S_XFER || st == S_ACK) && !wd_exp) wdog <= wdog + 1'b1;

            if (st_nx == S_BUSRST && st != S_BUSRST) rst_end <= (st != S_IDLE);
            if (st == S_BUSRST) need_rst <= 1'b0;

            if (st == S_IDLE && start) begin
                tries   <= '0;
                msg_got <= 1'b0;
                res_q   <= RC_PENDING;
                id_q    <= start_id;
            end else if ((st == S_FREE_A || st == S_FREE_B) && st_nx == S_DONE) begin
                res_q    <= RC_TIMEOUT;
                need_rst <= 1'b1;
            end else if ((st == S_FREE_A && !free_now) || (st == S_FREE_B && tmr_hit && !free_now)) begin
                tries <= tries + 1'b1;
            end else if (st == S_SELECT && st_nx == S_BUSRST) begin
                res_q <= RC_TIMEOUT;
            end else if (st == S_AWAIT_REQ && st_nx == S_BUSRST) begin
                res_q <= req_s ? RC_NOPTR : RC_TIMEOUT;
            end else if (fin != RC_PENDING) begin
                res_q <= fin;
            end

            if (st == S_AWAIT_REQ && st_nx == S_XFER) begin
                cur_phase <= PH_CMD;
                cur_ptr   <= new_ptr;
            end else if (ph_sw) begin
                cur_phase <= phase_s;
                cur_ptr   <= new_ptr;
            end else if (byte_go) begin
                cur_ptr <= cur_ptr + 1'b1;
                if (!cur_phase[0]) db_q <= mem_rdata;
                if (cur_phase == PH_MSGIN) msg_got <= 1'b1;
            end
        end
    end

    always_comb begin
        rst_o     = (st == S_BUSRST);
        sel_o     = (st == S_SELECT);
        ack_o     = (st == S_ACK);
        db_oe     = (st == S_SELECT) || (st == S_ACK && !cur_phase[0]);
        db_o      = (st == S_SELECT) ? id_q : db_q;
        done      = (st == S_DONE);
        result    = res_q;
        mem_addr  = cur_ptr;
        mem_wr    = byte_go && cur_phase[0];
        mem_wdata = db_s;
    end

    p_ack_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_s));
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> mem_addr == $past(mem_addr) + 1'b1);
    p_wr_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> phase_s[0]);
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result != 3'd0);
    p_ok_msg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 3'd1) |-> msg_got);
    p_rst_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |-> !db_oe && !sel_o && !ack_o);
endmodule

// File: tb/scsi_init_seq_test.sv
module scsi_init_seq_test;
    localparam int CLK      = 10;
    localparam int RST_CYC  = 6;
    localparam int FREE_GAP = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  start_id = '0;
    logic [63:0] start_ptrs = '0;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata, db_o;
    logic        mem_wr, db_oe, sel_o, ack_o, rst_o, done;
    logic [2:0]  result;
    logic [63:0] final_ptrs;
    logic [7:0]  db = '0;
    logic        bsy = 0, seli = 0, req = 0, cd = 0, io = 0, msg = 0, rsti = 0;
    logic [7:0]  mem [0:255];

    int checks = 0, fails = 0, cyc = 0, rst_len = 0;
    bit rst_seen = 0, ack_prev = 0;
    logic [7:0] cur_id = '0;

    always #(CLK/2) clk = ~clk;

    scsi_init_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_id(start_id),
        .start_ptrs(start_ptrs), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .db_i(db), .db_o(db_o),
        .db_oe(db_oe), .bsy_i(bsy), .sel_i(seli), .req_i(req), .cd_i(cd),
        .io_i(io), .msg_i(msg), .rst_i(rsti), .sel_o(sel_o), .ack_o(ack_o),
        .rst_o(rst_o), .done(done), .result(result), .final_ptrs(final_ptrs)
    );

    always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;
    assign mem_rdata = mem[mem_addr];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock reference monitor, a quarter period after the rising edge
    always @(posedge clk) begin
        #(CLK/4);
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
        if (rst_n) begin
            if (sel_o) chk(db_oe && db_o == cur_id, "R3 select data", db_o, cur_id);
            if (ack_o && !ack_prev) chk(req == 1'b1, "R6 ack after req", req, 1);
            if (rst_o) begin
                rst_seen = 1;
                rst_len++;
                chk(!db_oe, "R12 data released in reset", db_oe, 0);
            end else if (rst_len > 0) begin
                chk(rst_len == RST_CYC, "R12 reset length", rst_len, RST_CYC);
                rst_len = 0;
            end
            ack_prev = ack_o;
        end
    end

    function automatic logic [63:0] pk(input logic [7:0] s0, s1, s2, s3, s7);
        return {s7, 8'h00, 8'h00, 8'h00, s3, s2, s1, s0};
    endfunction

    function automatic logic [7:0] slot(input int k);
        return final_ptrs[k*8 +: 8];
    endfunction

    int elapsed;

    task automatic go(input logic [7:0] id, input logic [63:0] p);
        @(negedge clk);
        cur_id = id; start_id = id; start_ptrs = p; start = 1; rst_seen = 0;
        @(negedge clk);
        start = 0; elapsed = 1;
    endtask

    task automatic release_bus();
        @(negedge clk);
        bsy = 0; seli = 0; req = 0; cd = 0; io = 0; msg = 0; rsti = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic tgt_select(output bit ok);
        int n = 0;
        while (!sel_o && n < 400) begin @(negedge clk); n++; elapsed++; end
        ok = sel_o;
        bsy = 1;
        n = 0;
        while (sel_o && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic set_ph(input logic [2:0] p);
        @(negedge clk);
        {msg, cd, io} = p;
    endtask

    task automatic tgt_in(input logic [2:0] p, input logic [7:0] b);
        int n = 0;
        set_ph(p);
        db = b;
        @(negedge clk);
        req = 1;
        while (!ack_o && n < 500) begin @(negedge clk); n++; end
        req = 0;
        n = 0;
        while (ack_o && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic tgt_out(input logic [2:0] p, output logic [7:0] b);
        int n = 0;
        set_ph(p);
        @(negedge clk);
        req = 1;
        while (!ack_o && n < 500) begin @(negedge clk); n++; end
        b = db_oe ? db_o : 8'hxx;
        req = 0;
        n = 0;
        while (ack_o && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic wait_done(output bit ok);
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        ok = done;
    endtask

    logic [63:0] P;
    logic [7:0]  b0, b1, b2;
    bit          ok;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h10] = 8'hA1; mem[8'h11] = 8'hB2; mem[8'h12] = 8'hC3;
        P = pk(8'h20, 8'h40, 8'h10, 8'h60, 8'h70);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(!done && result == 0, "R1 done/result", {done, result}, 0);
        chk(!sel_o && !ack_o && !rst_o && !db_oe, "R1 bus outputs",
            {sel_o, ack_o, rst_o, db_oe}, 0);

        // normal command: cmd out, data in, status, message-in, BSY drop
        go(8'h04, P);
        tgt_select(ok);
        chk(ok, "R3 selection seen", ok, 1);
        chk(elapsed >= FREE_GAP + 1, "R2 bus-free gap", elapsed, FREE_GAP + 1);
        tgt_out(3'd2, b0); tgt_out(3'd2, b1); tgt_out(3'd2, b2);
        chk(b0 == 8'hA1 && b1 == 8'hB2 && b2 == 8'hC3, "R5 command bytes",
            {b0, b1, b2}, 24'hA1B2C3);
        tgt_in(3'd1, 8'h5A); tgt_in(3'd1, 8'h5B);
        tgt_in(3'd3, 8'h02);
        tgt_in(3'd7, 8'h00);
        @(negedge clk); bsy = 0;
        wait_done(ok);
        chk(ok && result == 1, "R9 ok result", result, 1);
        chk(!rst_seen, "R9 no reset on ok", rst_seen, 0);
        chk(mem[8'h40] == 8'h5A && mem[8'h41] == 8'h5B, "R5 data-in bytes",
            {mem[8'h40], mem[8'h41]}, 16'h5A5B);
        chk(mem[8'h60] == 8'h02, "R5 status byte", mem[8'h60], 2);
        chk(slot(2) == 8'h13, "R7 cmd pointer", slot(2), 8'h13);
        chk(slot(1) == 8'h42, "R7 data-in pointer", slot(1), 8'h42);
        chk(slot(3) == 8'h61 && slot(7) == 8'h71, "R7 status/msg pointers",
            {slot(3), slot(7)}, 16'h6171);
        chk(slot(0) == 8'h20, "R7 unused slot", slot(0), 8'h20);
        @(negedge clk);
        chk(!done && result == 1, "R12 done pulse, result held", {done, result}, 1);
        release_bus();

        // busy error: no message-in before BSY drop
        go(8'h02, P);
        tgt_select(ok);
        tgt_out(3'd2, b0);
        tgt_in(3'd3, 8'h02);
        @(negedge clk); bsy = 0;
        wait_done(ok);
        chk(ok && result == 2, "R9 busy error", result, 2);
        chk(rst_seen, "R12 reset before done", rst_seen, 1);
        chk(slot(2) == 8'h11 && slot(3) == 8'h61, "R7 pointers after error",
            {slot(2), slot(3)}, 16'h1161);
        release_bus();

        // bad phase: data-in slot is zero
        go(8'h08, pk(8'h20, 8'h00, 8'h10, 8'h60, 8'h70));
        tgt_select(ok);
        tgt_out(3'd2, b0);
        set_ph(3'd1);
        @(negedge clk); req = 1;
        wait_done(ok);
        chk(ok && result == 4, "R8 zero pointer", result, 4);
        chk(rst_seen, "R8 reset issued", rst_seen, 1);
        chk(slot(2) == 8'h11, "R7 saved on abort", slot(2), 8'h11);
        release_bus();

        // first phase not command
        go(8'h08, P);
        tgt_select(ok);
        set_ph(3'd3);
        @(negedge clk); req = 1;
        wait_done(ok);
        chk(ok && result == 4, "R4 first phase", result, 4);
        chk(rst_seen, "R4 reset issued", rst_seen, 1);
        release_bus();

        // selection timeout
        go(8'h10, P);
        wait_done(ok);
        chk(ok && result == 5, "R3 select timeout", result, 5);
        chk(rst_seen, "R3 reset issued", rst_seen, 1);
        release_bus();

        // REQ timeout
        go(8'h10, P);
        tgt_select(ok);
        wait_done(ok);
        chk(ok && result == 5, "R4 req timeout", result, 5);
        release_bus();

        // bus never free, then next command begins with reset
        @(negedge clk); bsy = 1;
        repeat (3) @(negedge clk);
        go(8'h01, P);
        wait_done(ok);
        chk(ok && result == 5, "R2 bus busy", result, 5);
        chk(!rst_seen, "R2 no reset at failure", rst_seen, 0);
        release_bus();
        go(8'h01, P);
        tgt_select(ok);
        chk(ok && rst_seen, "R2 reset before select", rst_seen, 1);
        tgt_out(3'd2, b0);
        tgt_in(3'd7, 8'h00);
        @(negedge clk); bsy = 0;
        wait_done(ok);
        chk(ok && result == 1, "R9 ok after recovery", result, 1);
        release_bus();

        // bus reset sensed while connected
        go(8'h20, P);
        tgt_select(ok);
        tgt_out(3'd2, b0);
        @(negedge clk); rsti = 1;
        wait_done(ok);
        chk(ok && result == 3, "R10 reset error", result, 3);
        release_bus();

        // watchdog while connected
        go(8'h40, P);
        tgt_select(ok);
        tgt_out(3'd2, b0);
        wait_done(ok);
        chk(ok && result == 5, "R11 watchdog", result, 5);
        chk(slot(2) == 8'h11, "R11 pointer saved", slot(2), 8'h11);
        chk(rst_seen, "R11 reset issued", rst_seen, 1);
        release_bus();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule